// File: doc/BRIEF.md
# Time-Shared Three-Term Weighted Sum Unit

This block forms the weighted sum of three unsigned samples, each multiplied by its own unsigned weight. It has one multiplier and one adder. A small sequencer passes the weight/sample pairs through them one pair per clock, so the area cost is one product term rather than three, and the price is a few cycles of latency per result.

A caller holds the six operands steady, pulses `start` for one cycle and waits for `done`. The operands are registered in front of the multiplier and the running total is registered after the adder. The longest register-to-register path is therefore one multiply followed by one add. The sequencer has three states:

- `SQ_IDLE` (waiting) moves to `SQ_ISSUE` on an accepted start.
- `SQ_ISSUE` (one pair registered per cycle) moves to `SQ_FLUSH` once the last pair index has been issued.
- `SQ_FLUSH` (the last product enters the total) always returns to `SQ_IDLE`.

Top module: `wsum3_mac`

## Requirements
- R1: When `done` is high, `result` equals k0*s0 + k1*s1 + k2*s2, computed over the operand values held since the accepted start.
- R2: `done` is high for exactly one cycle. It rises on the 4th rising clock edge after the edge that accepted `start`, and it is low at every other time.
- R3: The total is 2*DW+2 bits wide (18 bits for DW=8). With every operand at 255 the result is exactly 195075, with no wrap.
- R4: A `start` that is high while a computation is in progress has no effect. The running total is not cleared, and `done` keeps its original timing and value.
- R5: After `done`, `result` keeps the final sum while `start` stays low, even if the operands change.
- R6: After reset, `result` is 0 and `done` is 0.
- R7: An accepted `start` clears `result` to 0 on the same edge that accepts it.
- R8: Terms are taken in index order 0, 1, 2. One edge after the accepting edge `result` is still 0. After the second edge it equals k0*s0, and after the third it equals k0*s0 + k1*s1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a computation when idle |
| k0 | input | DW | Weight of term 0 |
| k1 | input | DW | Weight of term 1 |
| k2 | input | DW | Weight of term 2 |
| s0 | input | DW | Sample of term 0 |
| s1 | input | DW | Sample of term 1 |
| s2 | input | DW | Sample of term 2 |
| result | output | 2*DW+2 | Running total, then the final sum |
| done | output | 1 | One-cycle pulse when the sum is complete |

## Verification
The edge that accepts `start` is counted as edge 0. `result` is due at 0 one edge later. It then carries the first partial sum after edge 2, the second after edge 3, and the full sum with `done` high after edge 4. After edge 5 `done` is low and the sum is unchanged.

The bench drives inputs and samples outputs at falling edges, and checks each of those values in its own cycle. It sweeps all six operands over a five-value grid that includes 0 and full scale. One run keeps `start` high through the busy cycles, and another changes the operands after completion.

// File: rtl/wsum3_pkg.sv
package wsum3_pkg;
    localparam int unsigned NTERMS = 3;
    localparam int unsigned IW     = $clog2(NTERMS);

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_FLUSH
    } sq_state_t;
endpackage

// File: rtl/wsum3_seq.sv
module wsum3_seq
    import wsum3_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          clr,
    output logic          issue,
    output logic          last,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NTERMS - 1);

    sq_state_t state, nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= nxt;
    end

    // next-state
    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:  if (start)          nxt = SQ_ISSUE;
            SQ_ISSUE: if (idx == LAST_IDX) nxt = SQ_FLUSH;
            SQ_FLUSH:                      nxt = SQ_IDLE;
            default:                       nxt = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        clr   = (state == SQ_IDLE) && start;
        issue = (state == SQ_ISSUE);
        last  = issue && (idx == LAST_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              idx <= '0;
        else if (clr)            idx <= '0;
        else if (issue && !last) idx <= idx + IW'(1);
    end

    assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);
    assert_idx_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !last) |=> (idx == $past(idx) + IW'(1)));
    assert_flush_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_FLUSH) |=> (state == SQ_IDLE));
    assert_busy_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE && start) |=> (state != SQ_IDLE || $past(state) == SQ_FLUSH));
endmodule

// File: rtl/wsum3_opmux.sv
module wsum3_opmux
    import wsum3_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NTERMS-1:0][DW-1:0] wgt,
    input  logic [NTERMS-1:0][DW-1:0] smp,
    input  logic                      issue,
    input  logic                      last,
    input  logic [IW-1:0]             idx,
    output logic [DW-1:0]             op_w,
    output logic [DW-1:0]             op_s,
    output logic                      op_vld,
    output logic                      op_last
);
    logic [DW-1:0] sel_w, sel_s;

    always_comb begin
        sel_w = '0;
        sel_s = '0;
        for (int t = 0; t < NTERMS; t++) begin
            if (idx == IW'(t)) begin
                sel_w = wgt[t];
                sel_s = smp[t];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_w    <= '0;
            op_s    <= '0;
            op_vld  <= 1'b0;
            op_last <= 1'b0;
        end else begin
            op_vld  <= issue;
            op_last <= last;
            if (issue) begin
                op_w <= sel_w;
                op_s <= sel_s;
            end
        end
    end

    assert_last_is_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_last |-> op_vld);
    assert_terms_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && !op_last) |=> op_vld);
endmodule

// File: rtl/wsum3_mulacc.sv
module wsum3_mulacc #(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 2 * DW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] op_w,
    input  logic [DW-1:0] op_s,
    input  logic          op_vld,
    input  logic          op_last,
    output logic [AW-1:0] acc,
    output logic          done
);
    localparam int unsigned PW = 2 * DW;

    logic [PW-1:0] prod;
    logic [AW-1:0] sum;

    // the one multiplier and the one adder
    always_comb begin
        prod = op_w * op_s;
        sum  = acc + {{(AW - PW){1'b0}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            done <= 1'b0;
        end else begin
            done <= op_vld && op_last;
            if (clr)         acc <= '0;
            else if (op_vld) acc <= sum;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && !clr) |=> (acc >= $past(acc)));
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !op_vld) |=> $stable(acc));
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
endmodule

// File: rtl/wsum3_mac.sv
module wsum3_mac
    import wsum3_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned AW = 2 * DW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] k0,
    input  logic [DW-1:0] k1,
    input  logic [DW-1:0] k2,
    input  logic [DW-1:0] s0,
    input  logic [DW-1:0] s1,
    input  logic [DW-1:0] s2,
    output logic [AW-1:0] result,
    output logic          done
);
    logic [NTERMS-1:0][DW-1:0] wgt, smp;
    logic                      clr, issue, last;
    logic [IW-1:0]             idx;
    logic [DW-1:0]             op_w, op_s;
    logic                      op_vld, op_last;

    assign wgt = {k2, k1, k0};
    assign smp = {s2, s1, s0};

    wsum3_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .clr   (clr),
        .issue (issue),
        .last  (last),
        .idx   (idx)
    );

    wsum3_opmux #(.DW(DW)) u_opmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .wgt     (wgt),
        .smp     (smp),
        .issue   (issue),
        .last    (last),
        .idx     (idx),
        .op_w    (op_w),
        .op_s    (op_s),
        .op_vld  (op_vld),
        .op_last (op_last)
    );

    wsum3_mulacc #(.DW(DW), .AW(AW)) u_mulacc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .op_w    (op_w),
        .op_s    (op_s),
        .op_vld  (op_vld),
        .op_last (op_last),
        .acc     (result),
        .done    (done)
    );

    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(op_last));
endmodule

// File: tb/sim_wsum3_mac.sv
module sim_wsum3_mac;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 2 * DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] k0 = '0, k1 = '0, k2 = '0, s0 = '0, s1 = '0, s2 = '0;
    logic [AW-1:0] result;
    logic          done;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wsum3_mac #(.DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .k0(k0), .k1(k1), .k2(k2), .s0(s0), .s1(s1), .s2(s2),
        .result(result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_one(input int a0, input int a1, input int a2,
                           input int b0, input int b1, input int b2,
                           input bit keep_start);
        int p0, p1, tot;
        p0  = a0 * b0;
        p1  = p0 + a1 * b1;
        tot = p1 + a2 * b2;
        k0 = DW'(a0); k1 = DW'(a1); k2 = DW'(a2);
        s0 = DW'(b0); s1 = DW'(b1); s2 = DW'(b2);
        start = 1'b1;
        tick();                 // edge 0 accepts
        start = keep_start;     // R4: extra start while busy
        chk(result == 0, "R7 clear on start", int'(result), 0);
        chk(done == 1'b0, "R2 done low edge0", int'(done), 0);
        tick();                 // edge 1
        chk(result == 0, "R8 nothing summed yet", int'(result), 0);
        tick();                 // edge 2
        chk(result == AW'(p0), "R8 term0 first / R4 not cleared", int'(result), p0);
        tick();                 // edge 3
        chk(result == AW'(p1) && !done, "R8 term1 second", int'(result), p1);
        start = 1'b0;
        tick();                 // edge 4
        chk(done == 1'b1, "R2 done at edge4", int'(done), 1);
        chk(result == AW'(tot), "R1 sum", int'(result), tot);
        tick();                 // edge 5
        chk(done == 1'b0, "R2 done single", int'(done), 0);
        chk(result == AW'(tot), "R5 hold", int'(result), tot);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int grid [5];
        grid = '{0, 1, 85, 170, 255};
        repeat (3) @(negedge clk);
        chk(result == 0, "R6 reset result", int'(result), 0);
        chk(done == 1'b0, "R6 reset done", int'(done), 0);
        rst_n = 1'b1;
        tick();

        // R3: full scale
        run_one(255, 255, 255, 255, 255, 255, 1'b0);
        chk(result == AW'(195075), "R3 full scale", int'(result), 195075);

        // R4: start held high through the busy cycles
        run_one(3, 5, 7, 11, 13, 17, 1'b1);

        // R5: operands change after completion, result unchanged
        k0 = 8'd99; s2 = 8'd200;
        tick(); tick();
        chk(result == AW'(3*11 + 5*13 + 7*17), "R5 hold under new operands",
            int'(result), 3*11 + 5*13 + 7*17);
        chk(done == 1'b0, "R2 no stray done", int'(done), 0);

        // R1/R8 sweep over a grid including the extremes
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
                for (int c = 0; c < 5; c++)
                    for (int d = 0; d < 5; d++)
                        for (int e = 0; e < 5; e++)
                            for (int f = 0; f < 5; f++)
                                run_one(grid[a], grid[b], grid[c],
                                        grid[d], grid[e], grid[f], 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule